// File: doc/BRIEF.md
# RV64 Integer Execute Unit

This block is the combinational arithmetic and logic stage of a 64-bit RISC-V integer pipeline. Decode logic gives it an operation code, two source values, an optional 12-bit immediate and the destination register index. In the same cycle it returns the 64-bit result, a write-enable for the register file, and a flag that marks an unsupported operation code.

The unit supports full-width forms of add, subtract, xor, or, and, both set-less-than compares and all three shifts. It also supports the 32-bit word forms of add, subtract and the shifts. A word form computes on the low half of its operands and sign-extends the 32-bit result into all 64 bits. When the immediate is selected, it replaces the second source value after sign extension. This gives the I-type forms, including the immediate shifts.

Top module: `exec_unit`

## Requirements
- R1: Addition and subtraction wrap modulo 2^64 and raise no flag; for example, all-ones plus one gives zero, and zero minus one gives all-ones.
- R2: When use_imm_i is 1, the second operand is imm12_i (instruction bits 31:20) sign-extended from its bit 11 to 64 bits; for example, 0xFFF acts as -1 and 0x800 acts as -2048.
- R3: A 64-bit shift uses only the low 6 bits of the second operand as the shift amount.
- R4: A word shift uses only the low 5 bits of the second operand as the shift amount.
- R5: Every word operation (codes 10 to 14) sign-extends bit 31 of its 32-bit result into bits 63:32.
- R6: The signed compare (code 3) and the unsigned compare (code 4) return 1 when the first operand is less than the second, and 0 otherwise.
- R7: An arithmetic right shift fills with bit 63 in 64-bit mode and with bit 31 in word mode. A logical right shift fills with zeros.
- R8: The word logical right shift shifts the zero-extended low 32 bits of the first operand, then sign-extends the result; for example, 0x80000000 shifted by 1 gives 0x40000000.
- R9: The operation codes are: add 0, sub 1, sll 2, slt 3, sltu 4, xor 5, srl 6, sra 7, or 8, and 9, addw 10, subw 11, sllw 12, srlw 13, sraw 14. Any code from 15 to 31 gives a zero result, sets illegal_o and clears wr_en_o.
- R10: wr_en_o is 0 whenever rd_i is 0, and is 1 for any other rd_i with a legal code.
- R11: xor, or and and act bit by bit on the full 64-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| rs1_val_i | input | 64 | First source value |
| rs2_val_i | input | 64 | Second source value |
| use_imm_i | input | 1 | Use the immediate in place of rs2_val_i |
| imm12_i | input | 12 | Immediate field (instruction bits 31:20) |
| rd_i | input | 5 | Destination register index |
| result_o | output | 64 | Result |
| wr_en_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Unsupported operation code |

## Verification
The in-RTL checks are immediate assertions on settled combinational values. They assume that inputs change only between evaluations, never during one. The bench therefore drives every input in one step on the falling clock edge and samples 2 ns later. The checks assume no operand range, so the bench mixes directed corner values (sign boundaries, shift amounts with high bits set, rd of zero) with random 64-bit operands for every code.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned OPW  = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_SLL  = 5'd2,
    OP_SLT  = 5'd3,
    OP_SLTU = 5'd4,
    OP_XOR  = 5'd5,
    OP_SRL  = 5'd6,
    OP_SRA  = 5'd7,
    OP_OR   = 5'd8,
    OP_AND  = 5'd9,
    OP_ADDW = 5'd10,
    OP_SUBW = 5'd11,
    OP_SLLW = 5'd12,
    OP_SRLW = 5'd13,
    OP_SRAW = 5'd14
  } op_e;

  function automatic logic op_is_word(input logic [OPW-1:0] op);
    return (op >= 5'd10) && (op <= 5'd14);
  endfunction

  function automatic logic op_is_legal(input logic [OPW-1:0] op);
    return op <= 5'd14;
  endfunction
endpackage

// File: rtl/exec_operand.sv
module exec_operand #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IMMW = 12
) (
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic            use_imm_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] opb_o
);
  logic [XLEN-1:0] imm_sext;
  assign imm_sext = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
  assign opb_o    = use_imm_i ? imm_sext : rs2_val_i;

  always_comb begin
    // R2
    imm_sext_chk: assert (!use_imm_i || (opb_o[XLEN-1:IMMW-1] == '0) ||
                          (opb_o[XLEN-1:IMMW-1] == '1))
      else $error("immediate not sign-extended");
  end
endmodule

// File: rtl/exec_adder.sv
module exec_adder #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            word_i,
  output logic [XLEN-1:0] sum_o
);
  localparam int unsigned HW = XLEN / 2;
  logic [XLEN-1:0] b_eff, raw;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign raw   = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};  // carry out dropped: wraps
  assign sum_o = word_i ? {{HW{raw[HW-1]}}, raw[HW-1:0]} : raw;

  always_comb begin
    // R1
    no_overflow_chk: assert (word_i || sum_o == (sub_i ? a_i - b_i : a_i + b_i))
      else $error("sum does not wrap modulo 2^XLEN");
  end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]         val_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  logic                    right_i,
  input  logic                    arith_i,
  input  logic                    word_i,
  output logic [XLEN-1:0]         res_o
);
  localparam int unsigned HW  = XLEN / 2;
  localparam int unsigned SW  = $clog2(XLEN);
  localparam int unsigned SWW = $clog2(HW);

  logic [XLEN-1:0] src, shifted;
  logic [SW-1:0]   amt;
  logic            fill;

  always_comb begin
    if (word_i) begin
      fill = arith_i & val_i[HW-1];
      src  = {{HW{fill}}, val_i[HW-1:0]};
      amt  = {{(SW-SWW){1'b0}}, shamt_i[SWW-1:0]};
    end else begin
      fill = arith_i & val_i[XLEN-1];
      src  = val_i;
      amt  = shamt_i;
    end
  end

  always_comb begin
    if (!right_i)     shifted = src << amt;
    else if (arith_i) shifted = $signed(src) >>> amt;
    else              shifted = src >> amt;
  end

  assign res_o = word_i ? {{HW{shifted[HW-1]}}, shifted[HW-1:0]} : shifted;

  always_comb begin
    // R7
    sra_fill_chk: assert (!(right_i && arith_i && !word_i && val_i[XLEN-1]) || res_o[XLEN-1])
      else $error("arith shift lost sign");
    // R4
    word_amt_chk: assert (!word_i || amt < SW'(HW))
      else $error("word shift amount too wide");
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int unsigned DW   = exec_pkg::XLEN,
  parameter int unsigned IMMW = 12,
  parameter int unsigned RW   = 5
) (
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   rs1_val_i,
  input  logic [DW-1:0]   rs2_val_i,
  input  logic            use_imm_i,
  input  logic [IMMW-1:0] imm12_i,
  input  logic [RW-1:0]   rd_i,
  output logic [DW-1:0]   result_o,
  output logic            wr_en_o,
  output logic            illegal_o
);
  localparam int unsigned SW = $clog2(DW);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] opb, sum, shres;
  logic          is_sub, is_word, is_right, is_arith, legal;
  op_e           op;

  assign op      = op_e'(op_i);
  assign legal   = op_is_legal(op_i);
  assign is_word = op_is_word(op_i);
  assign is_sub  = (op == OP_SUB) || (op == OP_SUBW);
  assign is_right = (op == OP_SRL) || (op == OP_SRA) || (op == OP_SRLW) || (op == OP_SRAW);
  assign is_arith = (op == OP_SRA) || (op == OP_SRAW);

  exec_operand #(.XLEN(DW), .IMMW(IMMW)) u_operand (
    .rs2_val_i(rs2_val_i), .use_imm_i(use_imm_i), .imm_i(imm12_i), .opb_o(opb)
  );

  exec_adder #(.XLEN(DW)) u_adder (
    .a_i(rs1_val_i), .b_i(opb), .sub_i(is_sub), .word_i(is_word), .sum_o(sum)
  );

  exec_shifter #(.XLEN(DW)) u_shifter (
    .val_i(rs1_val_i), .shamt_i(opb[SW-1:0]), .right_i(is_right),
    .arith_i(is_arith), .word_i(is_word), .res_o(shres)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDW, OP_SUBW:            result_o = sum;
      OP_SLL, OP_SRL, OP_SRA, OP_SLLW, OP_SRLW, OP_SRAW: result_o = shres;
      OP_SLT:  result_o = {{(DW-1){1'b0}}, $signed(rs1_val_i) < $signed(opb)};
      OP_SLTU: result_o = {{(DW-1){1'b0}}, rs1_val_i < opb};
      OP_XOR:  result_o = rs1_val_i ^ opb;
      OP_OR:   result_o = rs1_val_i | opb;
      OP_AND:  result_o = rs1_val_i & opb;
      default: result_o = '0;
    endcase
  end

  assign illegal_o = ~legal;
  assign wr_en_o   = legal && (rd_i != '0);

  always_comb begin
    // R5
    word_sext_chk: assert (!(legal && is_word) || result_o[DW-1:HW-1] == '0 ||
                           result_o[DW-1:HW-1] == '1)
      else $error("word result not sign-extended");
    // R9
    illegal_zero_chk: assert (!illegal_o || (result_o == '0 && !wr_en_o))
      else $error("illegal op leaked a result");
    // R10
    rd_zero_chk: assert (rd_i != '0 || !wr_en_o)
      else $error("write enabled for register 0");
    // R6
    slt_bit_chk: assert (!(op_i == 5'd3 || op_i == 5'd4) || result_o[DW-1:1] == '0)
      else $error("compare result wider than one bit");
  end
endmodule

// File: tb/exec_unit_bench.sv
module exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [63:0] a, b, res;
  logic        use_imm, we, ill;
  logic [11:0] imm;
  logic [4:0]  rd;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  exec_unit u_exec_unit (
    .op_i(op), .rs1_val_i(a), .rs2_val_i(b), .use_imm_i(use_imm), .imm12_i(imm),
    .rd_i(rd), .result_o(res), .wr_en_o(we), .illegal_o(ill)
  );

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(input logic [4:0] o, input logic [63:0] x,
                                        input logic [63:0] y);
    logic [31:0] xl;
    xl = x[31:0];
    case (o)
      5'd0:  return x + y;
      5'd1:  return x - y;
      5'd2:  return x << y[5:0];
      5'd3:  return ($signed(x) < $signed(y)) ? 64'd1 : 64'd0;
      5'd4:  return (x < y) ? 64'd1 : 64'd0;
      5'd5:  return x ^ y;
      5'd6:  return x >> y[5:0];
      5'd7:  return 64'($signed(x) >>> y[5:0]);
      5'd8:  return x | y;
      5'd9:  return x & y;
      5'd10: return sx32(xl + y[31:0]);
      5'd11: return sx32(xl - y[31:0]);
      5'd12: return sx32(xl << y[4:0]);
      5'd13: return sx32(xl >> y[4:0]);
      5'd14: return sx32(32'($signed(xl) >>> y[4:0]));
      default: return 64'd0;
    endcase
  endfunction

  task automatic drive(input logic [4:0] o, input logic [63:0] x, input logic [63:0] y,
                       input logic ui, input logic [11:0] im, input logic [4:0] r);
    @(negedge clk);
    op = o; a = x; b = y; use_imm = ui; imm = im; rd = r;
    #2;
  endtask

  task automatic expect_out(input string tag, input logic [63:0] er, input logic ew,
                            input logic ei);
    checks++;
    if (res !== er || we !== ew || ill !== ei) begin
      errors++;
      $display("FAIL %s: op=%0d got res=%h we=%b ill=%b exp res=%h we=%b ill=%b",
               tag, op, res, we, ill, er, ew, ei);
    end
  endtask

  task automatic run_model(input string tag, input logic [4:0] o, input logic [63:0] x,
                           input logic [63:0] y);
    drive(o, x, y, 1'b0, 12'h0, 5'd7);
    expect_out(tag, model(o, x, y), 1'b1, 1'b0);
  endtask

  task automatic t_idle;
    drive(5'd0, 64'd0, 64'd0, 1'b0, 12'd0, 5'd0);
    expect_out("idle", 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_wrap;  // R1
    run_model("R1", 5'd0, '1, 64'd1);
    expect_out("R1 add wrap", 64'd0, 1'b1, 1'b0);
    run_model("R1", 5'd1, 64'd0, 64'd1);
    expect_out("R1 sub wrap", '1, 1'b1, 1'b0);
    run_model("R1 min-1", 5'd1, 64'h8000_0000_0000_0000, 64'd1);
  endtask

  task automatic t_imm;  // R2
    drive(5'd0, 64'd10, 64'hDEAD, 1'b1, 12'hFFF, 5'd3);
    expect_out("R2 imm -1", 64'd9, 1'b1, 1'b0);
    drive(5'd0, 64'd0, 64'd0, 1'b1, 12'h800, 5'd3);
    expect_out("R2 imm -2048", 64'hFFFF_FFFF_FFFF_F800, 1'b1, 1'b0);
    drive(5'd7, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 12'h404, 5'd3);
    expect_out("R2 srai imm", 64'hF800_0000_0000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_shamt64;  // R3
    drive(5'd2, 64'd1, 64'hFFFF_FF00_0000_0043, 1'b0, 12'd0, 5'd1);
    expect_out("R3 sll low6", 64'd8, 1'b1, 1'b0);
    drive(5'd6, 64'h8000_0000_0000_0000, 64'd63, 1'b0, 12'd0, 5'd1);
    expect_out("R3 srl 63", 64'd1, 1'b1, 1'b0);
  endtask

  task automatic t_shamtw;  // R4
    drive(5'd12, 64'd1, 64'd37, 1'b0, 12'd0, 5'd1);
    expect_out("R4 sllw low5", 64'd32, 1'b1, 1'b0);
    drive(5'd12, 64'd1, 64'd31, 1'b0, 12'd0, 5'd1);
    expect_out("R4 sllw 31", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_wsext;  // R5
    drive(5'd10, 64'h1234_5678_7FFF_FFFF, 64'd1, 1'b0, 12'd0, 5'd2);
    expect_out("R5 addw", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
    drive(5'd11, 64'd0, 64'hFFFF_FFFF_0000_0000, 1'b0, 12'd0, 5'd2);
    expect_out("R5 subw", 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_slt;  // R6
    drive(5'd3, '1, 64'd1, 1'b0, 12'd0, 5'd4);
    expect_out("R6 slt signed", 64'd1, 1'b1, 1'b0);
    drive(5'd4, '1, 64'd1, 1'b0, 12'd0, 5'd4);
    expect_out("R6 sltu", 64'd0, 1'b1, 1'b0);
    drive(5'd4, 64'd5, 64'd5, 1'b0, 12'd0, 5'd4);
    expect_out("R6 sltu equal", 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_sra;  // R7
    drive(5'd7, 64'h8000_0000_0000_0000, 64'd4, 1'b0, 12'd0, 5'd5);
    expect_out("R7 sra", 64'hF800_0000_0000_0000, 1'b1, 1'b0);
    drive(5'd14, 64'h0000_0000_8000_0000, 64'd4, 1'b0, 12'd0, 5'd5);
    expect_out("R7 sraw", 64'hFFFF_FFFF_F800_0000, 1'b1, 1'b0);
    drive(5'd6, 64'h8000_0000_0000_0000, 64'd4, 1'b0, 12'd0, 5'd5);
    expect_out("R7 srl zero fill", 64'h0800_0000_0000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_srlw;  // R8
    drive(5'd13, 64'hFFFF_FFFF_8000_0000, 64'd1, 1'b0, 12'd0, 5'd6);
    expect_out("R8 srlw 1", 64'h0000_0000_4000_0000, 1'b1, 1'b0);
    drive(5'd13, 64'h0000_0000_8000_0000, 64'd0, 1'b0, 12'd0, 5'd6);
    expect_out("R8 srlw 0", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;  // R9
    for (int c = 15; c < 32; c++) begin
      drive(5'(c), '1, '1, 1'b0, 12'd0, 5'd9);
      expect_out("R9 illegal", 64'd0, 1'b0, 1'b1);
    end
  endtask

  task automatic t_rd0;  // R10
    drive(5'd0, 64'd3, 64'd4, 1'b0, 12'd0, 5'd0);
    expect_out("R10 rd0", 64'd7, 1'b0, 1'b0);
    drive(5'd0, 64'd3, 64'd4, 1'b0, 12'd0, 5'd31);
    expect_out("R10 rd31", 64'd7, 1'b1, 1'b0);
  endtask

  task automatic t_logic;  // R11
    run_model("R11 xor", 5'd5, 64'hF0F0_0000_FFFF_1234, 64'h0FF0_FFFF_0000_4321);
    run_model("R11 or",  5'd8, 64'hF0F0_0000_FFFF_1234, 64'h0FF0_FFFF_0000_4321);
    run_model("R11 and", 5'd9, 64'hF0F0_0000_FFFF_1234, 64'h0FF0_FFFF_0000_4321);
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (i % 7 == 0) y = 64'($urandom % 80);
      run_model("R11 random", 5'(i % 15), x, y);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0; use_imm = 1'b0; imm = '0; rd = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_wrap();
    t_imm();
    t_shamt64();
    t_shamtw();
    t_wsext();
    t_slt();
    t_sra();
    t_srlw();
    t_illegal();
    t_rd0();
    t_logic();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule